// File: doc/BRIEF.md
# Prioritised Backplane Interrupter with Acknowledge Chain Node

This block is the interrupter on one board of a shared backplane that has seven prioritised, active-low interrupt request lines. Local logic offers an interrupt event over a valid/ready handshake. The block then pulls the request line for its configured level low. Many boards can sit on the same lines, and the interrupt handler picks one of them through an acknowledge token. That token enters the first slot and travels from board to board through an input and output pin on each board.

During an acknowledge cycle the handler puts the level it is serving on three address lines and pulls the address strobe low. If the level matches the board's own level and a request is pending, the block keeps the token. It drives its programmable status/ID byte onto the low data byte and pulls the transfer acknowledge low. The same clock edge withdraws the request. In every other case the block passes the token downstream on its acknowledge output, which follows the acknowledge input for as long as the strobe stays low.

The local event interface obeys one back-pressure rule. `raise_ready` is high exactly when no request is pending. An offer made while `raise_ready` is low is not stored. The offering logic must hold `raise_valid` until it sees `raise_ready`. All bus-side inputs are taken to be synchronous to `clk`.

Top module: `irq_chain_node`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, all `irq_n` bits are high, `dtack_n` and `iack_out_n` are high, `data_oe` is 0 and `raise_ready` is 1.
- R2: An event is accepted at a rising edge where `raise_valid` and `raise_ready` are both high. With `cfg_level` = L in 1..7, bit L-1 of `irq_n` is low from the next cycle and all other bits are high. With `cfg_level` = 0, no bit is driven low.
- R3: `raise_ready` is low while a request is pending. An offer made during that time is discarded and is not replayed after the request is withdrawn.
- R4: An acknowledge cycle begins at an edge where the block is idle and `as_n` and `iack_in_n` are both low. If `addr_lvl` equals a nonzero `cfg_level` and a request is pending, then from the next cycle `dtack_n` is low, `data_oe` is 1 and `data_out` holds the `cfg_status_id` sampled at that edge. `iack_out_n` stays high.
- R5: The edge that starts a response also withdraws the request, so all `irq_n` bits are high and `raise_ready` is 1 from the next cycle.
- R6: In an acknowledge cycle that does not lead to a response, `iack_out_n` is low from the next cycle while `as_n` and `iack_in_n` stay low. During that time `dtack_n` stays high and `data_oe` stays 0.
- R7: `iack_out_n` is high in every cycle in which `as_n` is high or `iack_in_n` is high, with no clock delay.
- R8: A rising edge at which `as_n` is high ends a response or a pass. From the next cycle `dtack_n` is high and `data_oe` is 0, and a new acknowledge cycle can begin.
- R9: An event accepted at the same edge that starts an acknowledge cycle for the block's own level is not answered in that cycle. The token is passed, and the request stays asserted.
- R10: `data_out` is all zeros whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 3 | Own interrupt level, 1..7; 0 disables requests |
| cfg_status_id | input | 8 | Status/ID byte returned on a response |
| raise_valid | input | 1 | Local logic offers an interrupt event |
| raise_ready | output | 1 | High when an event can be accepted (no request pending) |
| irq_n | output | 7 | Active-low request lines; bit i is level i+1 |
| as_n | input | 1 | Address strobe, active low |
| addr_lvl | input | 3 | Level being acknowledged (address lines 1..3) |
| iack_in_n | input | 1 | Acknowledge token in, active low |
| iack_out_n | output | 1 | Acknowledge token out to next board, active low |
| data_out | output | 8 | Status/ID onto the low data byte |
| data_oe | output | 1 | Data bus drive enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
Two functions can fall on the same clock edge: accepting a new local event, and deciding an acknowledge cycle for the block's own level. The bench provokes this by raising `raise_valid` while the block is idle, in the same cycle that it pulls `as_n` and `iack_in_n` low with the matching level on `addr_lvl`. The expected result is that the token is passed downstream, `dtack_n` stays high and the request line goes low. A behavioural model updated at each rising edge judges every cycle, and targeted checks confirm the pass and the asserted request.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned DEF_NUM_LEVELS = 7;
  localparam int unsigned DEF_ID_W       = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESPOND = 2'd1,
    ST_PASS    = 2'd2
  } ack_state_t;
endpackage

// File: rtl/irq_req_unit.sv
module irq_req_unit #(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned LVL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      cfg_level,
  input  logic                  raise_valid,
  output logic                  raise_ready,
  input  logic                  ack_clear,
  output logic                  pending,
  output logic [NUM_LEVELS-1:0] irq_n
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         pending_q <= 1'b0;
    else if (ack_clear)                 pending_q <= 1'b0;
    else if (raise_valid && !pending_q) pending_q <= 1'b1;
  end

  assign pending     = pending_q;
  assign raise_ready = !pending_q;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
    assign irq_n[g] = !(pending_q && (cfg_level == LVL_W'(g + 1)));
  end

  assert_accept_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && raise_ready && !ack_clear) |=> !raise_ready);

  assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clear |=> (&irq_n));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_chain_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             iack_in_n,
  input  logic [LVL_W-1:0] addr_lvl,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             pending,
  output logic             capture,
  output logic             respond,
  output logic             pass
);
  ack_state_t st_q, st_d;
  logic       start, hit;

  assign start = !as_n && !iack_in_n;
  assign hit   = pending && (cfg_level != '0) && (addr_lvl == cfg_level);

  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (hit) begin
          st_d    = ST_RESPOND;
          capture = 1'b1;
        end else begin
          st_d = ST_PASS;
        end
      end
      ST_RESPOND, ST_PASS: if (as_n) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign respond = (st_q == ST_RESPOND);
  assign pass    = (st_q == ST_PASS);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(respond && pass));

  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((respond || pass) && as_n) |=> (!respond && !pass));

  assert_resp_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!respond && !pass && start && !pending) |=> pass);
endmodule

// File: rtl/irq_id_driver.sv
module irq_id_driver #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            respond,
  input  logic [ID_W-1:0] cfg_status_id,
  output logic [ID_W-1:0] data_out,
  output logic            data_oe,
  output logic            dtack_n
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       id_q <= '0;
    else if (capture) id_q <= cfg_status_id;
  end

  assign data_oe  = respond;
  assign dtack_n  = !respond;
  assign data_out = respond ? id_q : '0;

  assert_id_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_out));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (data_out == $past(cfg_status_id)));
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irq_chain_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_NUM_LEVELS,
  parameter int unsigned ID_W       = DEF_ID_W,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      cfg_level,
  input  logic [ID_W-1:0]       cfg_status_id,
  input  logic                  raise_valid,
  output logic                  raise_ready,
  output logic [NUM_LEVELS-1:0] irq_n,
  input  logic                  as_n,
  input  logic [LVL_W-1:0]      addr_lvl,
  input  logic                  iack_in_n,
  output logic                  iack_out_n,
  output logic [ID_W-1:0]       data_out,
  output logic                  data_oe,
  output logic                  dtack_n
);
  logic pending, capture, respond, pass;

  irq_req_unit #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level),
    .raise_valid(raise_valid), .raise_ready(raise_ready),
    .ack_clear(capture), .pending(pending), .irq_n(irq_n)
  );

  irq_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .iack_in_n(iack_in_n),
    .addr_lvl(addr_lvl), .cfg_level(cfg_level), .pending(pending),
    .capture(capture), .respond(respond), .pass(pass)
  );

  irq_id_driver #(.ID_W(ID_W)) u_id (
    .clk(clk), .rst_n(rst_n), .capture(capture), .respond(respond),
    .cfg_status_id(cfg_status_id), .data_out(data_out),
    .data_oe(data_oe), .dtack_n(dtack_n)
  );

  // token leaves only during a pass, and only while strobe and token-in are low
  assign iack_out_n = !(pass && !as_n && !iack_in_n);

  assert_gate_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || iack_in_n) |-> iack_out_n);

  assert_keep_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> iack_out_n);

  assert_oe_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/test_irq_chain_node.sv
module test_irq_chain_node;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_level = 3'd0;
  logic [7:0] cfg_status_id = 8'h00;
  logic       raise_valid = 1'b0;
  logic       raise_ready;
  logic [6:0] irq_n;
  logic       as_n = 1'b1;
  logic [2:0] addr_lvl = 3'd0;
  logic       iack_in_n = 1'b1;
  logic       iack_out_n;
  logic [7:0] data_out;
  logic       data_oe;
  logic       dtack_n;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_node i_irq_chain_node (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_status_id(cfg_status_id),
    .raise_valid(raise_valid), .raise_ready(raise_ready), .irq_n(irq_n),
    .as_n(as_n), .addr_lvl(addr_lvl), .iack_in_n(iack_in_n), .iack_out_n(iack_out_n),
    .data_out(data_out), .data_oe(data_oe), .dtack_n(dtack_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 responding, 2 passing
  int m_pend = 0;
  int m_st = 0;
  logic [7:0] m_id = 8'h00;

  always @(posedge clk) begin
    int nst;
    bit clr;
    nst = m_st;
    clr = 0;
    started = 1;
    if (!rst_n) begin
      m_pend = 0;
      m_st = 0;
    end else begin
      if (m_st == 0) begin
        if (!as_n && !iack_in_n) begin
          if (m_pend != 0 && cfg_level != 0 && addr_lvl == cfg_level) begin
            nst = 1; clr = 1; m_id = cfg_status_id;
          end else nst = 2;
        end
      end else if (as_n) nst = 0;
      if (clr) m_pend = 0;
      else if (raise_valid && m_pend == 0) m_pend = 1;
      m_st = nst;
    end
  end

  function automatic logic [6:0] exp_irq();
    if (m_pend != 0 && cfg_level != 0) return ~(7'd1 << (cfg_level - 1));
    return 7'h7f;
  endfunction

  always @(negedge clk) begin
    #2;
    if (started) begin
      chk(irq_n == exp_irq(), "R2 model irq_n", {25'd0, irq_n}, {25'd0, exp_irq()});
      chk(raise_ready == (m_pend == 0), "R3 model raise_ready", raise_ready, m_pend == 0);
      chk(dtack_n == (m_st != 1), "R4 model dtack_n", dtack_n, m_st != 1);
      chk(data_oe == (m_st == 1), "R8 model data_oe", data_oe, m_st == 1);
      chk(data_out == ((m_st == 1) ? m_id : 8'h00), "R10 model data_out",
          data_out, (m_st == 1) ? m_id : 8'h00);
      chk(iack_out_n == !(m_st == 2 && !as_n && !iack_in_n), "R6/R7 model iack_out_n",
          iack_out_n, !(m_st == 2 && !as_n && !iack_in_n));
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic raise_one();
    @(negedge clk); raise_valid = 1'b1;
    @(negedge clk); raise_valid = 1'b0; #1;
  endtask

  task automatic begin_ack(input logic [2:0] lvl);
    @(negedge clk); as_n = 1'b0; iack_in_n = 1'b0; addr_lvl = lvl;
    @(negedge clk); #1;
  endtask

  task automatic end_ack();
    @(negedge clk); as_n = 1'b1; iack_in_n = 1'b1; #1;
    chk(iack_out_n == 1'b1, "R7 strobe high forces token-out high", iack_out_n, 1'b1);
    @(negedge clk); #1;
    chk(dtack_n == 1'b1 && data_oe == 1'b0, "R8 cycle end releases", {dtack_n, data_oe}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(irq_n == 7'h7f && dtack_n && iack_out_n && !data_oe && raise_ready,
        "R1 reset state", {irq_n, dtack_n, iack_out_n, data_oe, raise_ready}, {7'h7f, 4'b1101});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(irq_n == 7'h7f && raise_ready, "R1 after reset", {irq_n, raise_ready}, {7'h7f, 1'b1});

    cfg_level = 3'd3; cfg_status_id = 8'hA5;
    raise_one();
    chk(irq_n == 7'b1111011, "R2 level 3 line low", irq_n, 7'b1111011);
    chk(raise_ready == 1'b0, "R3 ready low while pending", raise_ready, 1'b0);

    // offer while pending: must be discarded
    @(negedge clk); raise_valid = 1'b1;
    repeat (3) step();
    @(negedge clk); raise_valid = 1'b0;

    // mismatched level: pass
    begin_ack(3'd5);
    chk(iack_out_n == 1'b0 && dtack_n == 1'b1, "R6 mismatch passes token", {iack_out_n, dtack_n}, 2'b01);
    @(negedge clk); iack_in_n = 1'b1; #1;
    chk(iack_out_n == 1'b1, "R7 token-in high forces token-out high", iack_out_n, 1'b1);
    end_ack();
    chk(irq_n == 7'b1111011, "R2 request held after pass", irq_n, 7'b1111011);

    // matching level: respond
    begin_ack(3'd3);
    chk(dtack_n == 1'b0 && data_oe && data_out == 8'hA5, "R4 response with status",
        {dtack_n, data_oe, data_out}, {2'b01, 8'hA5});
    chk(iack_out_n == 1'b1, "R4 token kept", iack_out_n, 1'b1);
    chk(irq_n == 7'h7f && raise_ready, "R5 request withdrawn", {irq_n, raise_ready}, {7'h7f, 1'b1});
    cfg_status_id = 8'h3C; step();
    chk(data_out == 8'hA5, "R4 status held from decision edge", data_out, 8'hA5);
    end_ack();
    chk(irq_n == 7'h7f, "R3 discarded offer not replayed", irq_n, 7'h7f);
    chk(data_out == 8'h00, "R10 data zero when idle", data_out, 8'h00);

    // own level but nothing pending: pass
    begin_ack(3'd3);
    chk(iack_out_n == 1'b0 && dtack_n, "R6 no pending passes", {iack_out_n, dtack_n}, 2'b01);
    end_ack();

    // same-edge raise and own-level acknowledge
    @(negedge clk); raise_valid = 1'b1; as_n = 1'b0; iack_in_n = 1'b0; addr_lvl = 3'd3;
    @(negedge clk); raise_valid = 1'b0; #1;
    chk(iack_out_n == 1'b0 && dtack_n == 1'b1, "R9 same-edge passes", {iack_out_n, dtack_n}, 2'b01);
    chk(irq_n == 7'b1111011, "R9 request stays asserted", irq_n, 7'b1111011);
    end_ack();
    begin_ack(3'd3);
    chk(dtack_n == 1'b0 && data_out == 8'h3C, "R4 later response", {dtack_n, data_out}, {1'b0, 8'h3C});
    end_ack();

    // boundary levels
    cfg_level = 3'd7; raise_one();
    chk(irq_n == 7'b0111111, "R2 level 7", irq_n, 7'b0111111);
    begin_ack(3'd7); end_ack();
    cfg_level = 3'd1; raise_one();
    chk(irq_n == 7'b1111110, "R2 level 1", irq_n, 7'b1111110);
    begin_ack(3'd1); end_ack();
    cfg_level = 3'd0; raise_one();
    chk(irq_n == 7'h7f, "R2 level 0 drives none", irq_n, 7'h7f);
    begin_ack(3'd0);
    chk(iack_out_n == 1'b0 && dtack_n, "R6 level 0 never responds", {iack_out_n, dtack_n}, 2'b01);
    end_ack();

    repeat (2) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule